// File: doc/BRIEF.md
# Self-Calibrating Sample Turn and Gap Detector

The block watches a stream of 8-bit amplitude samples, each marked by a valid strobe, and measures how many sample periods pass before the signal does something of interest. After reset it first learns the resting level of the signal. It averages the first 32 valid samples and keeps the result as a baseline. A guard band of three codes above and below that baseline then sets two thresholds.

After calibration the block accepts measurement requests. Each request carries a mode and a period limit. The modes are:
- **Turn mode:** the block stops when the signal reaches an extreme beyond the guard band and starts to move back. It alternates between looking for a trough and looking for a peak.
- **Gap mode:** it stops on a sample of exactly zero, which means the field has dropped out completely.
- **Wait mode:** it simply counts samples up to the limit.

A measurement reports the number of samples it consumed. It reports zero when the limit ran out or when it was aborted. Every sample consumed by a measurement is echoed on a logging strobe for an external capture buffer.

Top module: `tdet_top`

## Requirements
- R1: After reset, the first 32 valid samples are summed and the baseline is set to the sum shifted right by 5, with `cal_done` rising after the 32nd. Until then a start request is ignored and `busy` stays low.
- R2: The upper threshold is baseline + 3 and the lower threshold is baseline − 3, both in 8-bit modulo arithmetic. A previous sample equal to a threshold does not count as beyond it.
- R3: In turn mode (`mode` = 2'b00) with `seek_peak` = 0, a sample fires when the previous sample is below the lower threshold and the current sample is greater than or equal to it. `seek_peak` then becomes 1.
- R4: In turn mode with `seek_peak` = 1, a sample fires when the previous sample is above the upper threshold and the current sample is less than or equal to it. `seek_peak` then becomes 0.
- R5: In gap mode (`mode` = 2'b01), a sample fires only when it equals 0, and `seek_peak` is left unchanged.
- R6: Each valid sample during a measurement adds one to the count before it is evaluated. On a firing sample, `done` pulses for one cycle in the cycle after that sample's clock edge, with `result` equal to the count including that sample.
- R7: If a non-firing sample brings the count to `limit` or beyond, the measurement ends with `result` = 0. A limit of 0 therefore ends after the first sample.
- R8: In wait mode (`mode[1]` = 1), no sample fires. The measurement ends with `result` = 0 after `limit` samples, and `seek_peak` is unchanged.
- R9: Reset sets `seek_peak` to 0, the previous-sample register to 8'hFF, and `busy`, `done`, `log_valid` and `cal_done` to 0.
- R10: The previous-sample register takes every measurement sample that does not fire, in every mode. It keeps its value between measurements.
- R11: `abort` while busy ends the measurement on the next cycle. It gives `done` = 1, `result` = 0 and a log strobe carrying 8'hFF, and any sample offered in that cycle is discarded. `abort` while idle has no effect.
- R12: `busy` is high from the cycle after an accepted start until the cycle in which `done` is high, where it is low. A start while busy is ignored. `mode` and `limit` are captured at the accepted start.
- R13: Each sample consumed by a measurement appears on `log_valid`/`log_data` one cycle later. Calibration samples and samples offered while idle are not logged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 8 | Sample value |
| start | input | 1 | Measurement request |
| mode | input | 2 | 00 turn, 01 gap, 1x wait |
| limit | input | 16 | Period limit for the measurement |
| abort | input | 1 | End the running measurement early |
| cal_done | output | 1 | Baseline is valid |
| baseline | output | 8 | Calibrated mean |
| busy | output | 1 | Measurement running |
| done | output | 1 | One-cycle result strobe |
| result | output | 16 | Period count, 0 on timeout or abort |
| seek_peak | output | 1 | 1 = next turn sought is a peak |
| log_valid | output | 1 | Log strobe |
| log_data | output | 8 | Logged sample, or 8'hFF on abort |

## Verification
The checker watches, on every cycle, the relations that hold independently of the sample values. These are: `busy` only after calibration, `cal_done` never falling, the polarity changing only together with a non-zero result, abort answered on the next cycle with a zero result and an 8'hFF log word, `busy` ending only through `done`, and no log strobe without a running measurement. Other behaviour depends on the actual sample sequence: where a turn fires relative to the thresholds, that a threshold-equal sample does not count, the reset value of the previous sample, its persistence across measurements, and the exact count reported. Only the bench's directed and random scenarios can show these, by comparing against its own sample-by-sample model.

// File: rtl/tdet_pkg.sv
package tdet_pkg;

    typedef enum logic [1:0] {
        MD_TURN = 2'd0,
        MD_GAP  = 2'd1,
        MD_WAIT = 2'd2
    } meas_mode_e;

    function automatic meas_mode_e decode_mode(input logic [1:0] raw);
        if (raw[1])
            return MD_WAIT;
        else if (raw[0])
            return MD_GAP;
        else
            return MD_TURN;
    endfunction

endpackage

// File: rtl/tdet_baseline.sv
module tdet_baseline #(
    parameter int W        = 8,
    parameter int CAL_LOG2 = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W-1:0] smp_data,
    output logic         cal_done,
    output logic [W-1:0] baseline
);
    localparam int AW = W + CAL_LOG2;

    typedef struct packed {
        logic [AW-1:0]       acc;
        logic [CAL_LOG2-1:0] n;
        logic                done;
        logic [W-1:0]        base;
    } cal_regs_t;

    cal_regs_t q, d;
    logic [AW-1:0] acc_nx;

    always_comb begin
        d      = q;
        acc_nx = q.acc + AW'(smp_data);
        if (smp_valid && !q.done) begin
            d.acc = acc_nx;
            d.n   = q.n + 1'b1;
            if (q.n == '1) begin
                d.done = 1'b1;
                d.base = acc_nx[AW-1:CAL_LOG2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign cal_done = q.done;
    assign baseline = q.base;

endmodule

// File: rtl/tdet_turn_eval.sv
module tdet_turn_eval
    import tdet_pkg::*;
#(
    parameter int W      = 8,
    parameter int MARGIN = 3
) (
    input  meas_mode_e   mode,
    input  logic         seek_peak,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] base,
    output logic         hit
);
    localparam logic [W-1:0] GUARD = W'(MARGIN);

    logic [W-1:0] upper, lower;

    always_comb begin
        upper = base + GUARD;
        lower = base - GUARD;
        unique case (mode)
            MD_TURN: hit = seek_peak ? ((prev > upper) && (cur <= prev))
                                     : ((prev < lower) && (cur >= prev));
            MD_GAP:  hit = (cur == '0);
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/tdet_top.sv
module tdet_top
    import tdet_pkg::*;
#(
    parameter int W        = 8,
    parameter int CW       = 16,
    parameter int MARGIN   = 3,
    parameter int CAL_LOG2 = 5,
    parameter bit LOG_EN   = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid,
    input  logic [W-1:0]  smp_data,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] limit,
    input  logic          abort,
    output logic          cal_done,
    output logic [W-1:0]  baseline,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] result,
    output logic          seek_peak,
    output logic          log_valid,
    output logic [W-1:0]  log_data
);
    typedef struct packed {
        logic          busy;
        meas_mode_e    mode;
        logic [CW-1:0] lim;
        logic [CW-1:0] cnt;
        logic          seek;
        logic [W-1:0]  prev;
        logic          done;
        logic [CW-1:0] res;
        logic          log_v;
        logic [W-1:0]  log_d;
    } run_regs_t;

    localparam run_regs_t RUN_RST = '{
        busy: 1'b0, mode: MD_TURN, lim: '0, cnt: '0, seek: 1'b0,
        prev: '1, done: 1'b0, res: '0, log_v: 1'b0, log_d: '0
    };

    run_regs_t q, d;
    logic          hit;
    logic [CW-1:0] cnt_inc;

    tdet_baseline #(.W(W), .CAL_LOG2(CAL_LOG2)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .cal_done  (cal_done),
        .baseline  (baseline)
    );

    tdet_turn_eval #(.W(W), .MARGIN(MARGIN)) u_eval (
        .mode      (q.mode),
        .seek_peak (q.seek),
        .prev      (q.prev),
        .cur       (smp_data),
        .base      (baseline),
        .hit       (hit)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.log_v = 1'b0;
        cnt_inc = q.cnt + 1'b1;
        if (!q.busy) begin
            if (start && cal_done) begin
                d.busy = 1'b1;
                d.cnt  = '0;
                d.mode = decode_mode(mode);
                d.lim  = limit;
            end
        end else if (abort) begin
            d.busy  = 1'b0;
            d.done  = 1'b1;
            d.res   = '0;
            d.log_v = 1'b1;
            d.log_d = '1;
        end else if (smp_valid) begin
            d.cnt   = cnt_inc;
            d.log_v = 1'b1;
            d.log_d = smp_data;
            if (hit) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.res  = cnt_inc;
                if (q.mode == MD_TURN)
                    d.seek = !q.seek;
            end else begin
                d.prev = smp_data;
                if (cnt_inc >= q.lim) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    d.res  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RUN_RST;
        else
            q <= d;
    end

    assign busy      = q.busy;
    assign done      = q.done;
    assign result    = q.res;
    assign seek_peak = q.seek;

    generate
        if (LOG_EN) begin : g_log
            assign log_valid = q.log_v;
            assign log_data  = q.log_d;
        end else begin : g_nolog
            assign log_valid = 1'b0;
            assign log_data  = '0;
        end
    endgenerate

endmodule

// File: rtl/tdet_chk.sv
module tdet_chk #(
    parameter int W      = 8,
    parameter int CW     = 16,
    parameter bit LOG_EN = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          abort,
    input logic          cal_done,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] result,
    input logic          seek_peak,
    input logic          log_valid,
    input logic [W-1:0]  log_data
);

    assert_busy_after_cal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cal_done);

    assert_cal_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |=> cal_done);

    // R3 and R4: polarity only moves when a turn is reported
    assert_flip_on_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(seek_peak) |-> (done && result != '0));

    assert_abort_reply_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (done && !busy && result == '0));

    generate
        if (LOG_EN) begin : g_logchk
            assert_abort_log_R11: assert property (@(posedge clk) disable iff (!rst_n)
                (busy && abort) |=> (log_valid && log_data == '1));
        end
    endgenerate

    assert_busy_ends_on_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    assert_log_only_running_R13: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid |-> $past(busy));

endmodule

bind tdet_top tdet_chk #(.W(W), .CW(CW), .LOG_EN(LOG_EN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort),
    .cal_done  (cal_done),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .seek_peak (seek_peak),
    .log_valid (log_valid),
    .log_data  (log_data)
);

// File: tb/tdet_top_tb.sv
module tdet_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_data = '0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic [15:0] limit = '0;
    logic        abort = 1'b0;
    logic        cal_done, busy, done, seek_peak, log_valid;
    logic [7:0]  baseline, log_data;
    logic [15:0] result;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    logic [7:0] B;
    logic [7:0] m_prev;
    bit         m_seek;
    int         walk;

    always #5 clk = ~clk;

    tdet_top u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .start(start), .mode(mode), .limit(limit), .abort(abort),
        .cal_done(cal_done), .baseline(baseline), .busy(busy), .done(done),
        .result(result), .seek_peak(seek_peak), .log_valid(log_valid),
        .log_data(log_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model_hit(input logic [1:0] md, input bit sk,
                                     input logic [7:0] pv, input logic [7:0] cur);
        logic [7:0] up, lo;
        up = B + 8'd3;
        lo = B - 8'd3;
        if (md[1]) return 1'b0;
        if (md[0]) return (cur == 8'd0);
        if (sk) return (pv > up) && (cur <= pv);
        return (pv < lo) && (cur >= pv);
    endfunction

    function automatic logic [7:0] next_smp(input logic [1:0] md);
        if (md == 2'b01 && $urandom_range(0, 14) == 0) return 8'd0;
        walk = walk + int'($urandom_range(0, 6)) - 3;
        if (walk < int'(B) - 15) walk = int'(B) - 15;
        if (walk > int'(B) + 15) walk = int'(B) + 15;
        return 8'(walk);
    endfunction

    task automatic measure(input logic [1:0] md, input int lim, input int abort_at,
                           input logic [7:0] dir[$], input int idle_pct, output int got);
        int cnt;
        int idx;
        int guard;
        bit fin;
        string tg;
        cnt = 0; idx = 0; guard = 0; fin = 0; got = -1;
        tg = (md == 2'b00) ? "R3 R4 R6 R7" : (md == 2'b01) ? "R5 R6 R7" : "R8";
        @(negedge clk);
        start = 1'b1; mode = md; limit = 16'(lim);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R12 busy after start", busy, 1);
        while (!fin && guard < 2000) begin
            bit e_done, e_log;
            int e_res;
            logic [7:0] e_ld, s;
            e_done = 0; e_log = 0; e_res = 0; e_ld = '0;
            guard++;
            smp_valid = 1'b0; abort = 1'b0;
            start = ($urandom_range(0, 9) == 0);
            mode = 2'($urandom_range(0, 3)); limit = 16'($urandom_range(0, 3));
            if (idx == abort_at) begin
                abort = 1'b1;
                smp_valid = $urandom_range(0, 1) == 1;
                smp_data = 8'd0;
                e_done = 1; e_res = 0; e_log = 1; e_ld = 8'hFF; fin = 1;
                idx++;
            end else if (int'($urandom_range(0, 99)) < idle_pct) begin
                smp_data = 8'($urandom);
            end else begin
                s = (idx < dir.size()) ? dir[idx] : next_smp(md);
                smp_valid = 1'b1; smp_data = s;
                idx++; cnt++;
                e_log = 1; e_ld = s;
                if (model_hit(md, m_seek, m_prev, s)) begin
                    e_done = 1; e_res = cnt; fin = 1;
                    if (md == 2'b00) m_seek = !m_seek;
                end else begin
                    m_prev = s;
                    if (cnt >= lim) begin
                        e_done = 1; e_res = 0; fin = 1;
                    end
                end
            end
            @(negedge clk);
            smp_valid = 1'b0; abort = 1'b0; start = 1'b0;
            chk(done == e_done, {tg, " done timing"}, done, e_done);
            if (e_done) begin
                chk(result == 16'(e_res), {tg, " R11 result"}, result, e_res);
                got = int'(result);
            end
            chk(busy == !fin, "R12 busy window", busy, !fin);
            chk(seek_peak == m_seek, "R3 R4 R5 R8 polarity", seek_peak, m_seek);
            chk(log_valid == e_log && (!e_log || log_data == e_ld),
                "R13 R11 log echo", {log_valid, log_data}, {e_log, e_ld});
        end
        if (!fin) chk(0, "R6 measurement never ended", 0, 1);
    endtask

    initial begin
        #(10 * 150000);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] q[$];
        logic [7:0] nodir[$];
        int sum;
        int got;
        void'($urandom(32'd1234));
        m_prev = 8'hFF; m_seek = 0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(busy == 0 && done == 0 && log_valid == 0, "R9 reset outputs", {busy, done, log_valid}, 0);
        chk(seek_peak == 0 && cal_done == 0, "R9 reset polarity and cal", {seek_peak, cal_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 0, "R1 start ignored before calibration", busy, 0);

        sum = 0;
        for (int k = 1; k <= 32; k++) begin
            logic [7:0] v;
            if ($urandom_range(0, 3) == 0) @(negedge clk);
            v = 8'($urandom_range(110, 140));
            sum += int'(v);
            smp_valid = 1'b1; smp_data = v;
            @(negedge clk);
            smp_valid = 1'b0;
            chk(cal_done == (k == 32), "R1 calibration length", cal_done, k == 32);
            chk(log_valid == 0, "R13 calibration not logged", log_valid, 0);
        end
        B = 8'(sum >> 5);
        walk = int'(B);
        chk(baseline == B, "R1 baseline mean", baseline, B);

        // R9 R3: reset previous value 0xFF blocks the first sample
        q = {8'(B - 8'd8), 8'(B - 8'd9), 8'(B - 8'd10), 8'(B - 8'd10)};
        measure(2'b00, 20, -1, q, 0, got);
        chk(got == 4, "R9 R3 first trough", got, 4);

        // R2 R4: threshold-equal previous sample does not count
        q = {8'(B + 8'd3), 8'(B + 8'd2), 8'(B + 8'd4), 8'(B + 8'd5), 8'(B + 8'd5)};
        measure(2'b00, 20, -1, q, 0, got);
        chk(got == 5, "R2 R4 peak turn", got, 5);

        // R5 gap mode
        q = {8'(B - 8'd8), 8'd3, 8'd0};
        measure(2'b01, 10, -1, q, 0, got);
        chk(got == 3, "R5 zero sample", got, 3);

        // R8 wait mode
        q = {8'd0, 8'(B - 8'd10), 8'(B + 8'd10), 8'(B - 8'd10), 8'(B + 8'd10), 8'(B + 8'd1)};
        measure(2'b10, 6, -1, q, 0, got);
        chk(got == 0, "R8 wait counts to limit", got, 0);

        // R7 timeout and zero limit
        q = {B, B, B, B, B};
        measure(2'b00, 5, -1, q, 0, got);
        chk(got == 0, "R7 timeout", got, 0);
        q = {B};
        measure(2'b00, 0, -1, q, 0, got);
        chk(got == 0, "R7 zero limit", got, 0);

        // R10 previous sample persists across measurements
        q = {8'(B + 8'd1), 8'(B - 8'd10)};
        measure(2'b11, 2, -1, q, 0, got);
        q = {8'(B - 8'd10)};
        measure(2'b00, 10, -1, q, 0, got);
        chk(got == 1, "R10 persisted previous", got, 1);

        // R11 abort while running and while idle
        measure(2'b00, 50, 2, nodir, 0, got);
        chk(got == 0, "R11 abort result", got, 0);
        @(negedge clk);
        abort = 1'b1; smp_valid = 1'b1; smp_data = 8'd0;
        @(negedge clk);
        abort = 1'b0; smp_valid = 1'b0;
        chk(done == 0 && log_valid == 0 && busy == 0, "R11 idle abort ignored",
            {done, log_valid, busy}, 0);

        for (int r = 0; r < 40; r++) begin
            logic [1:0] md;
            int lim, ab;
            md = 2'($urandom_range(0, 3));
            lim = ($urandom_range(0, 9) == 0) ? 0 : int'($urandom_range(1, 60));
            ab = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 20)) : -1;
            measure(md, lim, ab, nodir, 20, got);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule